// File: doc/BRIEF.md
# Pulse-Width Decision Sender with Saturation Clamp

The block sits between a 1-bit oversampling modulator and its serial link. It runs on a 16 MHz reference clock and receives a one-cycle sample tick at a 1 MHz rate. On each tick it captures the comparator decision into a register. That register also sets the polarity of the feedback DAC. On the same tick it starts a high pulse on the serial line for the decision captured one tick earlier. A +1 decision gives a short pulse and a -1 decision gives a long one. Every pulse starts on a tick, so a receiver can rebuild the sample clock from the rising edges. It then reads the sign by sampling the line halfway through the period.

The block also tracks how many decisions in a row have had the same sign. A long run of equal decisions means the loop has saturated. When the run grows past the limit, the block raises a clamp request so that the higher-order integrators are bypassed and the loop behaves as a first-order one. The request drops on the first decision of the opposite sign.

Top module: `pwm_bit_sender`

## Requirements
- R1: While rst_n is low and right after it is released, line_out, bit_q and clamp are all 0.
- R2: On a clock edge with tick high, bit_q takes the value of cmp_bit. Changes of cmp_bit in cycles without tick have no effect on bit_q.
- R3: A captured 1 (meaning +1) is sent as line_out high for exactly SHORT_CYC (default 4) consecutive clock cycles.
- R4: A captured 0 (meaning -1) is sent as line_out high for exactly LONG_CYC (default 12) consecutive clock cycles.
- R5: A pulse goes high in the cycle right after a tick edge and carries the bit captured at the previous tick. The first tick after reset sends no pulse.
- R6: clamp rises at the tick edge that captures the (RUN_LIMIT+1)-th consecutive equal decision (default: the 16th). It stays low for runs of RUN_LIMIT or fewer.
- R7: The run counter saturates instead of wrapping, so clamp stays high for an arbitrarily long run of equal decisions.
- R8: clamp falls at the tick edge that captures a decision different from the previous one. The run then restarts from 1, so it takes RUN_LIMIT+1 equal decisions again to raise clamp.
- R9: Without ticks, line_out stays low once the current pulse is complete, and bit_q and clamp hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample strobe at the 1 MHz rate |
| cmp_bit | input | 1 | Comparator decision, 1 = +1, 0 = -1 |
| line_out | output | 1 | Pulse-width encoded serial line |
| bit_q | output | 1 | Captured decision, drives the DAC polarity |
| clamp | output | 1 | Overload request for the integrator clamp switches |

## Verification
The bench drives directed runs of exactly RUN_LIMIT and RUN_LIMIT+1 equal decisions. A design that counts from 0 instead of 1, or compares with >= instead of >, would raise clamp one decision early or one decision late. A run several times longer than the counter range checks for wraparound, which would make clamp drop in the middle of the overload. The first tick after reset checks for a spurious pulse from an unprimed register. Toggling cmp_bit between ticks checks for a capture that is not gated by the tick. Random runs of 1 to 25 decisions catch a pulse that encodes the new bit instead of the previous one, or a width that is off by one cycle.

// File: rtl/pwm_bit_sender.sv
module pwm_bit_sender #(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 12,
  parameter int RUN_LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cmp_bit,
  output logic line_out,
  output logic bit_q,
  output logic clamp
);
  localparam int PW      = $clog2(LONG_CYC + 1);
  localparam int RW      = $clog2(RUN_LIMIT + 2);
  localparam int RUN_TOP = RUN_LIMIT + 1;

  logic          primed;
  logic [PW-1:0] pcnt;
  logic [RW-1:0] run;
  logic [RW-1:0] run_nxt;
  logic [PW-1:0] width;
  logic          same;

  assign same     = primed && (cmp_bit == bit_q);
  assign run_nxt  = !same ? RW'(1) : (run == RW'(RUN_TOP) ? run : run + RW'(1));
  assign width    = bit_q ? PW'(SHORT_CYC) : PW'(LONG_CYC);
  assign line_out = (pcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0;
      bit_q  <= 1'b0;
      pcnt   <= '0;
      run    <= '0;
      clamp  <= 1'b0;
    end else if (tick) begin
      primed <= 1'b1;
      bit_q  <= cmp_bit;
      pcnt   <= primed ? width : '0;
      run    <= run_nxt;
      clamp  <= (run_nxt > RW'(RUN_LIMIT));
    end else if (pcnt != '0) begin
      pcnt <= pcnt - PW'(1);
    end
  end
endmodule

module pwm_bit_sender_chk #(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 12,
  parameter int RUN_LIMIT = 15
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic cmp_bit,
  input logic line_out,
  input logic bit_q,
  input logic clamp
);
  logic [7:0] hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_len <= '0;
    else if (line_out && hi_len != 8'hFF) hi_len <= hi_len + 8'd1;
    else if (!line_out) hi_len <= '0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (!line_out && !clamp && !bit_q));

  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(bit_q));

  a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_out) |-> $past(tick));

  a_r3_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_out) |-> (hi_len == 8'(SHORT_CYC) || hi_len == 8'(LONG_CYC)));

  a_r6_rise_same_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp) |-> ($past(tick) && $stable(bit_q)));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp && tick && (cmp_bit != bit_q)) |=> !clamp);

  a_r7_hold_same: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp && tick && (cmp_bit == bit_q)) |=> clamp);
endmodule

bind pwm_bit_sender pwm_bit_sender_chk #(
  .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .RUN_LIMIT(RUN_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_bit(cmp_bit),
  .line_out(line_out), .bit_q(bit_q), .clamp(clamp)
);

// File: tb/pwm_bit_sender_test.sv
module pwm_bit_sender_test;
  localparam int SHORT_CYC = 4;
  localparam int LONG_CYC  = 12;
  localparam int RUN_LIMIT = 15;
  localparam int PERIOD    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cmp_bit = 1'b0;
  logic line_out, bit_q, clamp;

  int checks = 0;
  int failures = 0;

  bit m_primed = 1'b0;
  bit m_prev = 1'b0;
  int m_run = 0;

  always #4 clk = ~clk;

  pwm_bit_sender #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .RUN_LIMIT(RUN_LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_bit(cmp_bit),
    .line_out(line_out), .bit_q(bit_q), .clamp(clamp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_width(input bit primed, input bit prev);
    if (!primed) return 0;
    return prev ? SHORT_CYC : LONG_CYC;
  endfunction

  function automatic logic [PERIOD-1:0] exp_shape(input int w);
    logic [PERIOD-1:0] v = '0;
    for (int i = 0; i < PERIOD; i++) if (i < w) v[i] = 1'b1;
    return v;
  endfunction

  // caller is at a negedge; one full sample period follows
  task automatic issue(input bit b, input bit jitter);
    int w;
    string tag;
    logic [PERIOD-1:0] obs;
    w = exp_width(m_primed, m_prev);
    tag = !m_primed ? "R5" : (m_prev ? "R3" : "R4");
    m_run = (m_primed && b == m_prev) ? m_run + 1 : 1;
    m_primed = 1'b1;
    m_prev = b;
    tick = 1'b1;
    cmp_bit = b;
    obs = '0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      tick = 1'b0;
      obs[i] = line_out;
      if (i == 0) begin
        check(bit_q == b, "R2", int'(bit_q), int'(b));
        check(clamp == (m_run > RUN_LIMIT),
              (m_run > RUN_LIMIT) ? "R6" : "R8", int'(clamp), int'(m_run > RUN_LIMIT));
      end
      if (jitter) cmp_bit = 1'($urandom);
    end
    check(obs == exp_shape(w), tag, int'(obs), int'(exp_shape(w)));
    check(bit_q == b, "R2", int'(bit_q), int'(b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!line_out && !bit_q && !clamp, "R1", int'({line_out, bit_q, clamp}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!line_out && !bit_q && !clamp, "R1", int'({line_out, bit_q, clamp}), 0);

    issue(1'b1, 1'b1);
    issue(1'b0, 1'b1);
    issue(1'b1, 1'b0);
    issue(1'b1, 1'b1);
    // run of 15 zeros: no clamp; 16th zero: clamp (R6)
    for (int k = 0; k < RUN_LIMIT; k++) issue(1'b0, 1'b1);
    check(clamp == 1'b0, "R6", int'(clamp), 0);
    issue(1'b0, 1'b1);
    check(clamp == 1'b1, "R6", int'(clamp), 1);
    // long run well past any counter wrap (R7)
    for (int k = 0; k < 80; k++) begin
      issue(1'b0, 1'b1);
      check(clamp == 1'b1, "R7", int'(clamp), 1);
    end
    // first opposite decision releases, new run restarts from 1 (R8)
    issue(1'b1, 1'b1);
    check(clamp == 1'b0, "R8", int'(clamp), 0);
    for (int k = 0; k < RUN_LIMIT - 1; k++) issue(1'b1, 1'b1);
    check(clamp == 1'b0, "R8", int'(clamp), 0);
    issue(1'b1, 1'b1);
    check(clamp == 1'b1, "R8", int'(clamp), 1);

    // idle without ticks (R9)
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cmp_bit = 1'($urandom);
      check(!line_out && bit_q == m_prev && clamp == (m_run > RUN_LIMIT), "R9",
            int'({line_out, bit_q, clamp}), int'({1'b0, m_prev, (m_run > RUN_LIMIT)}));
    end

    // random runs
    for (int r = 0; r < 40; r++) begin
      bit b = 1'($urandom);
      int len = 1 + int'($urandom % 25);
      for (int k = 0; k < len; k++) issue(b, 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule